// File: doc/BRIEF.md
# Halfword Pack and Insert Unit

This datapath unit assembles a 32-bit word out of 16-bit halves taken from two source operands. Two pack orders are offered. In bottom-top order the first operand gives the low half and a left-shifted copy of the second operand gives the high half. In top-bottom order the first operand gives the high half and an arithmetically right-shifted copy of the second operand gives the low half. Only the second operand ever passes through the shifter, and the shift direction follows from the pack order.

A third mode inserts the low halfword of the second operand into the upper half of a destination word and keeps the destination's lower half. Each operation presented with `in_valid` produces a registered result, and `out_valid` rises one clock later. Operations can be issued back to back, one per cycle.

Top module: `hpack_unit`

## Requirements
- R1: With `mode` = 2'b00 (bottom-top) and `shamt` between 1 and 15, `result[15:0]` equals `op_a[15:0]` and `result[31:16]` equals bits [15:0] of `op_b` shifted left by `shamt`, with zeros shifted in at the bottom.
- R2: With `mode` = 2'b01 (top-bottom) and `shamt` between 1 and 31, `result[31:16]` equals `op_a[15:0]` and `result[15:0]` equals bits [15:0] of `op_b` arithmetically shifted right by `shamt`, with copies of `op_b[31]` filling from the top.
- R3: With `mode` = 2'b00 and `shamt` = 0, the raw halfwords are packed: `result` = {`op_b[15:0]`, `op_a[15:0]`}.
- R4: With `mode` = 2'b01 and `shamt` = 0, the shift is taken as 32, so every bit of `result[15:0]` equals `op_b[31]`, and `result[31:16]` equals `op_a[15:0]`.
- R5: With `mode[1]` = 1 (2'b10 or 2'b11, insert), `result[31:16]` equals `op_b[15:0]` and `result[15:0]` equals `dst[15:0]`. `op_a` and `shamt` have no effect.
- R6: In bottom-top mode with `shamt` of 16 or more, every bit of `op_b` leaves the low 16 bits of the shifted value, so `result[31:16]` is zero and `result[15:0]` is still `op_a[15:0]`.
- R7: `out_valid` is high exactly one cycle after a cycle in which `in_valid` was high, and `result` then carries that operation's value. After a cycle with `in_valid` low, `out_valid` is low and `result` keeps its previous value.
- R8: A synchronous reset drives `out_valid` and `result` to zero on the next clock edge. Reset has priority over `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| mode | input | 2 | 00 bottom-top, 01 top-bottom, 1x insert |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, the one that is shifted |
| dst | input | 32 | Destination word for insert mode |
| shamt | input | 5 | Shift immediate |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Registered packed word |

## Verification
Two events can fall in the same cycle. The first is the presentation of one result and the acceptance of the next operation. The bench issues every vector back to back, so each result is checked in the same cycle that a new, different vector is captured, and any bleed between operations shows as a miscompare. The second is a reset that arrives together with `in_valid`. The bench drives both in one cycle and expects both `out_valid` and `result` to be zero afterwards.

// File: rtl/hpack_unit.sv
module hpack_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic [W-1:0]         dst,
  input  logic [$clog2(W)-1:0] shamt,
  output logic                 out_valid,
  output logic [W-1:0]         result
);
  localparam int H = W / 2;

  logic [W-1:0] lsh;
  logic [W-1:0] rsh;
  logic [W-1:0] packed_w;

  assign lsh = op_b << shamt;
  assign rsh = (shamt == '0) ? {W{op_b[W-1]}} : W'($signed(op_b) >>> shamt);

  always_comb begin
    unique case (mode)
      2'b00:   packed_w = {lsh[H-1:0], op_a[H-1:0]};
      2'b01:   packed_w = {op_a[H-1:0], rsh[H-1:0]};
      default: packed_w = {op_b[H-1:0], dst[H-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= packed_w;
    end
  end
endmodule

module hpack_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [1:0]           mode,
  input logic [W-1:0]         op_a,
  input logic [W-1:0]         op_b,
  input logic [W-1:0]         dst,
  input logic [$clog2(W)-1:0] shamt,
  input logic                 out_valid,
  input logic [W-1:0]         result
);
  localparam int H = W / 2;

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_drops_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_bt_low_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> result[H-1:0] == $past(op_a[H-1:0]));
  p_bt_raw_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && shamt == '0) |=> result[W-1:H] == $past(op_b[H-1:0]));
  p_bt_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && shamt >= H) |=> result[W-1:H] == '0);
  p_tb_high_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> result[W-1:H] == $past(op_a[H-1:0]));
  p_tb_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01 && shamt == '0) |=> result[H-1:0] == {H{$past(op_b[W-1])}});
  p_insert_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1]) |=> result == {$past(op_b[H-1:0]), $past(dst[H-1:0])});
endmodule

bind hpack_unit hpack_unit_chk #(.W(W)) u_chk (.*);

// File: tb/hpack_unit_bench.sv
module hpack_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic [31:0] op_a, op_b, dst;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] result;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hpack_unit u_hpack_unit (.*);

  function automatic logic [31:0] model(input logic [1:0] m, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] d,
                                        input int sh);
    logic [15:0] hi, lo;
    if (m[1]) return {b[15:0], d[15:0]};
    if (m == 2'b00) begin
      for (int i = 0; i < 16; i++) hi[i] = (i >= sh) ? b[i-sh] : 1'b0;
      return {hi, a[15:0]};
    end
    for (int i = 0; i < 16; i++) begin
      int src = i + ((sh == 0) ? 32 : sh);
      lo[i] = (src > 31) ? b[31] : b[src];
    end
    return {a[15:0], lo};
  endfunction

  task automatic check(input string tag, input logic v, input logic [31:0] got,
                       input logic ev, input logic [31:0] exp);
    vectors++;
    if (v !== ev || got !== exp) begin
      fails++;
      $display("FAIL %s: actual valid=%0b result=%08h expected valid=%0b result=%08h",
               tag, v, got, ev, exp);
    end
  endtask

  initial begin
    logic [31:0] pa [6] = '{32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF,
                            32'hA5A5_5A5A, 32'h8000_0001, 32'h7FFF_FFFE};
    logic [31:0] pb [6] = '{32'h8765_4321, 32'h7FFF_8001, 32'h8000_0000,
                            32'hC3C3_3C3C, 32'hFFFF_FFFF, 32'h0001_0000};
    logic [31:0] prev;
    rst = 1'b1; in_valid = 1'b0; mode = '0; op_a = '0; op_b = '0; dst = '0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", out_valid, result, 1'b0, 32'h0);
    rst = 1'b0;

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 32; s++)
        for (int p = 0; p < 6; p++) begin
          string tag;
          logic [31:0] e;
          mode = m[1:0]; shamt = s[4:0];
          op_a = pa[p]; op_b = pb[(p + s) % 6]; dst = pa[(p + 3) % 6] ^ 32'h3C5A_0F96;
          in_valid = 1'b1;
          e = model(m[1:0], op_a, op_b, dst, s);
          if (m >= 2) tag = "R5 insert";
          else if (m == 0) tag = (s == 0) ? "R3 raw pack" : (s >= 16) ? "R6 shift-out" : "R1 bottom-top";
          else tag = (s == 0) ? "R4 sign fill" : "R2 top-bottom";
          @(negedge clk);
          check(tag, out_valid, result, 1'b1, e);
        end

    prev = result;
    in_valid = 1'b0; op_a = 32'hDEAD_BEEF; op_b = 32'h0BAD_F00D; mode = 2'b10;
    @(negedge clk);
    check("R7 idle hold", out_valid, result, 1'b0, prev);
    @(negedge clk);
    check("R7 idle hold 2", out_valid, result, 1'b0, prev);

    in_valid = 1'b1; mode = 2'b00; shamt = 5'd4; op_a = 32'h1111_2222; op_b = 32'h0000_0ABC;
    @(negedge clk);
    check("R7 latency", out_valid, result, 1'b1, 32'hABC0_2222);

    rst = 1'b1; in_valid = 1'b1; mode = 2'b01; op_a = 32'hFFFF_FFFF; op_b = 32'h8000_0000;
    @(negedge clk);
    check("R8 reset beats valid", out_valid, result, 1'b0, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 after reset", out_valid, result, 1'b0, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual run still busy expected run complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule